// File: doc/BRIEF.md
# Indirect DMA Channel Configuration Window

This block is a memory-mapped register slave. It holds per-channel DMA configuration words that have no addresses of their own. A host reaches any of them through two bus registers: a control register and a data register.

The host writes a control word that names a bank (the mode), a channel index and a command, and sets the start bit. The block then stays busy for a fixed number of cycles. When it finishes, it either copies the data register into the selected entry or loads the entry into the data register. It then clears the busy bit by itself.

Two banks are debug status views. They are filled from an input port and cannot be written from the bus. A read-only capability register reports the transmit and receive virtual channel counts in a compressed 5-bit code. An optional auto-increment steps the channel index after each access, so that consecutive channels can be walked.

Top module: `dma_cfg_window`

## Requirements
- R1: After reset the control register, the data register and every writable bank entry read as zero.
- R2: A write is done by loading the data register (offset 0x3084) and then writing the control register (offset 0x3080) with command bit 1 = 0 and start bit 0 = 1. On completion the data word is stored in the entry selected by mode and channel, and the data register keeps its value.
- R3: A control write with command bit 1 = 1 and start bit 0 = 1 loads the selected entry into the data register when the access completes.
- R4: The busy bit (control bit 0) reads 1 for exactly BUSY_CYCLES cycles (default 2) after an accepted start write, and then reads 0.
- R5: While busy is set, writes to the control register and to the data register are ignored.
- R6: Modes 0, 1, 4 and 5 are four independent storage banks, each with NUM_CH entries.
- R7: An access with a channel index of NUM_CH or more, or with a mode code above 5, changes no storage. Such a read returns zero.
- R8: Modes 2 and 3 read the status input word of the selected channel: transmit status at word index ch and receive status at word index NUM_CH+ch of dbgStatus. Writes to these modes are dropped.
- R9: When the auto-increment field (control bits 5:4) is nonzero, the channel field advances by one, modulo 128, after each completed access.
- R10: The capability register (offset 0x0128) holds the transmit code in bits 22:18 and the receive code in bits 16:12. Codes decode as follows:
  - 0 to 15 mean code+1.
  - 16 to 19 mean 20 to 32 in steps of 4.
  - 20 to 23 mean 40 to 64 in steps of 8.
  - 24 to 27 mean 80 to 128 in steps of 16.
  The codes are derived from the count parameters, rounding up.
- R11: The control register reads back as follows: mode in bits 27:24, channel in bits 14:8, auto-increment in bits 5:4, command in bit 1, busy in bit 0, all other bits zero. A control write with start 0 only updates the fields. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset of the register accessed |
| busWr | input | 1 | Write strobe for busWdata |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| dbgStatus | input | 2*NUM_CH*32 | Transmit then receive debug status words, one per channel |

## Verification
The hardest states to reach are those where the host acts while an access is still in flight. Examples are a second control word that must be dropped, or a data-register write that would corrupt a pending store. The bench issues these writes on the very cycle after an accepted start. It then reads back both the control fields and the stored entry once the window closes.

Aliasing is the other hard case. An out-of-range channel whose low bits match a real entry must leave that entry intact. The bench stores to channel NUM_CH and then reads channel 0.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  localparam int DW = 32;

  // Control word field positions
  localparam int MODE_LSB = 24;
  localparam int CHAN_LSB = 8;
  localparam int INC_LSB  = 4;
  localparam int CMD_BIT  = 1;
  localparam int BUSY_BIT = 0;

  localparam logic [3:0] MODE_TXCFG  = 4'd0;
  localparam logic [3:0] MODE_RXCFG  = 4'd1;
  localparam logic [3:0] MODE_TXDBG  = 4'd2;
  localparam logic [3:0] MODE_RXDBG  = 4'd3;
  localparam logic [3:0] MODE_TXDESC = 4'd4;
  localparam logic [3:0] MODE_RXDESC = 4'd5;

  typedef struct packed {
    logic commit;   // access completes this cycle
    logic isRead;   // completing access is a read
  } dcwStrobe_t;

  // Smallest compressed code whose decoded count covers n (1..128)
  function automatic logic [4:0] encodeCount(input int n);
    int code;
    if (n <= 16)      code = n - 1;
    else if (n <= 32) code = 16 + ((n <= 20) ? 0 : (n - 20 + 3) / 4);
    else if (n <= 64) code = 20 + ((n <= 40) ? 0 : (n - 40 + 7) / 8);
    else              code = 24 + ((n <= 80) ? 0 : (n - 80 + 15) / 16);
    return 5'(code);
  endfunction
endpackage

// File: rtl/dcw_ctrl.sv
module dcw_ctrl
  import dcw_pkg::*;
#(
  parameter int BUSY_CYCLES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctlWrEn,
  input  logic [DW-1:0]   wdata,
  output logic [3:0]      mode,
  output logic [6:0]      chan,
  output logic [1:0]      inc,
  output logic            isRd,
  output logic            busy,
  output dcwStrobe_t      stb
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= '0;
      chan <= '0;
      inc  <= '0;
      isRd <= 1'b0;
      busy <= 1'b0;
      cntQ <= '0;
    end else if (ctlWrEn && !busy) begin
      mode <= wdata[MODE_LSB +: 4];
      chan <= wdata[CHAN_LSB +: 7];
      inc  <= wdata[INC_LSB +: 2];
      isRd <= wdata[CMD_BIT];
      busy <= wdata[BUSY_BIT];
      cntQ <= CNT_W'(BUSY_CYCLES);
    end else if (busy) begin
      if (cntQ == CNT_W'(1)) begin
        busy <= 1'b0;
        cntQ <= '0;
        if (inc != 2'd0) chan <= chan + 7'd1;
      end else begin
        cntQ <= cntQ - CNT_W'(1);
      end
    end
  end

  always_comb begin
    stb.commit = busy && (cntQ == CNT_W'(1));
    stb.isRead = isRd;
  end
endmodule

// File: rtl/dcw_datapath.sv
module dcw_datapath
  import dcw_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dataWrEn,
  input  logic [DW-1:0]          wdata,
  input  dcwStrobe_t             stb,
  input  logic [3:0]             mode,
  input  logic [6:0]             chan,
  input  logic [2*NUM_CH*DW-1:0] dbgStatus,
  output logic [DW-1:0]          dataQ
);
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int NBANK = 4;

  logic [CH_W-1:0] chIdx;
  logic            inRange, modeOk, writable, valid;
  logic [1:0]      bankIdx;
  logic [DW-1:0]   bankQ [NBANK*NUM_CH];
  logic [DW-1:0]   rdWord;

  assign chIdx    = chan[CH_W-1:0];
  assign inRange  = (int'(chan) < NUM_CH);
  assign modeOk   = (mode <= MODE_RXDESC);
  assign valid    = inRange && modeOk;
  assign writable = (mode == MODE_TXCFG) || (mode == MODE_RXCFG) ||
                    (mode == MODE_TXDESC) || (mode == MODE_RXDESC);

  always_comb begin
    case (mode)
      MODE_TXCFG:  bankIdx = 2'd0;
      MODE_RXCFG:  bankIdx = 2'd1;
      MODE_TXDESC: bankIdx = 2'd2;
      default:     bankIdx = 2'd3;
    endcase
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar c = 0; c < NUM_CH; c++) begin : g_entry
      logic [DW-1:0] entryQ;
      always_ff @(posedge clk) begin
        if (!rstN) entryQ <= '0;
        else if (stb.commit && !stb.isRead && valid && writable &&
                 bankIdx == 2'(b) && chIdx == CH_W'(c))
          entryQ <= dataQ;
      end
      assign bankQ[b*NUM_CH + c] = entryQ;
    end
  end

  always_comb begin
    rdWord = '0;
    if (valid) begin
      if (writable)                rdWord = bankQ[int'(bankIdx)*NUM_CH + int'(chIdx)];
      else if (mode == MODE_TXDBG) rdWord = dbgStatus[int'(chIdx)*DW +: DW];
      else                         rdWord = dbgStatus[(NUM_CH + int'(chIdx))*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         dataQ <= '0;
    else if (stb.commit && stb.isRead) dataQ <= rdWord;
    else if (dataWrEn)                 dataQ <= wdata;
  end
endmodule

// File: rtl/dma_cfg_window.sv
module dma_cfg_window
  import dcw_pkg::*;
#(
  parameter int              NUM_CH      = 8,
  parameter int              BUSY_CYCLES = 2,
  parameter int              TX_VCH      = 24,
  parameter int              RX_VCH      = 8,
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 16'h3080,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h3084,
  parameter logic [ADDR_W-1:0] CAP_ADDR  = 16'h0128
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWr,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  input  logic [2*NUM_CH*32-1:0] dbgStatus
);
  localparam logic [4:0] TX_CODE = encodeCount(TX_VCH);
  localparam logic [4:0] RX_CODE = encodeCount(RX_VCH);

  logic       ctlWrEn, dataWrEn, busy, isRd, commitStb;
  logic [3:0] mode;
  logic [6:0] chan;
  logic [1:0] inc;
  logic [DW-1:0] dataQ, ctlView, capWord;
  dcwStrobe_t stb;

  assign ctlWrEn   = busWr && (busAddr == CTL_ADDR);
  assign dataWrEn  = busWr && (busAddr == DATA_ADDR) && !busy;
  assign commitStb = stb.commit;

  dcw_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .wdata(busWdata),
    .mode(mode), .chan(chan), .inc(inc), .isRd(isRd), .busy(busy), .stb(stb)
  );

  dcw_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .dataWrEn(dataWrEn), .wdata(busWdata), .stb(stb),
    .mode(mode), .chan(chan), .dbgStatus(dbgStatus), .dataQ(dataQ)
  );

  assign ctlView = {4'b0, mode, 9'b0, chan, 2'b0, inc, 2'b0, isRd, busy};
  assign capWord = {9'b0, TX_CODE, 1'b0, RX_CODE, 12'b0};

  always_comb begin
    if (busAddr == CTL_ADDR)       busRdata = ctlView;
    else if (busAddr == DATA_ADDR) busRdata = dataQ;
    else if (busAddr == CAP_ADDR)  busRdata = capWord;
    else                           busRdata = '0;
  end
endmodule

// File: rtl/dma_cfg_window_chk.sv
module dma_cfg_window_chk #(
  parameter int NUM_CH      = 8,
  parameter int BUSY_CYCLES = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        ctlWrEn,
  input logic        commitStb,
  input logic        isRd,
  input logic [3:0]  mode,
  input logic [6:0]  chan,
  input logic [1:0]  inc,
  input logic [31:0] dataQ
);
  int lenQ;
  always_ff @(posedge clk) begin
    if (!rstN)     lenQ <= 0;
    else if (busy) lenQ <= lenQ + 1;
    else           lenQ <= 0;
  end

  a_r4_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> lenQ == BUSY_CYCLES);

  a_r5_ignore_ctl: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctlWrEn) |=> ($stable(mode) && $stable(isRd)));

  a_r2_write_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    (commitStb && !isRd) |=> $stable(dataQ));

  a_r7_bad_chan_zero: assert property (@(posedge clk) disable iff (!rstN)
    (commitStb && isRd && int'(chan) >= NUM_CH) |=> dataQ == 32'd0);

  a_r9_auto_inc: assert property (@(posedge clk) disable iff (!rstN)
    (commitStb && inc != 2'd0) |=> chan == $past(chan) + 7'd1);
endmodule

bind dma_cfg_window dma_cfg_window_chk #(.NUM_CH(NUM_CH), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .ctlWrEn(ctlWrEn), .commitStb(commitStb),
  .isRd(isRd), .mode(mode), .chan(chan), .inc(inc), .dataQ(dataQ)
);

// File: tb/dma_cfg_window_tb.sv
module dma_cfg_window_tb;
  localparam int NUM_CH = 8;
  localparam int TX_VCH = 24;
  localparam int RX_VCH = 8;
  localparam logic [15:0] CTL = 16'h3080, DAT = 16'h3084, CAP = 16'h0128;

  logic clk = 1'b0, rstN = 1'b0, busWr = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [2*NUM_CH*32-1:0] dbgStatus;
  int nChk = 0, nFail = 0;

  always #2.5 clk = ~clk;

  dma_cfg_window #(.NUM_CH(NUM_CH), .TX_VCH(TX_VCH), .RX_VCH(RX_VCH)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .dbgStatus(dbgStatus));

  function automatic logic [31:0] statWord(int m, int ch);
    return 32'h5000_0000 | (m << 16) | ch;
  endfunction

  function automatic logic [31:0] pat(int m, int ch);
    return {8'hC3, 4'(m), 4'h9, 8'(ch), 8'(ch * 7 + m)};
  endfunction

  function automatic logic [31:0] ctlw(int m, int ch, int inc, bit rd, bit st);
    return (32'(m) << 24) | (32'(ch & 127) << 8) | (32'(inc & 3) << 4) |
           (32'(rd) << 1) | 32'(st);
  endfunction

  function automatic int decode(logic [4:0] c);
    if (c < 16) return int'(c) + 1;
    if (c < 20) return 20 + (int'(c) - 16) * 4;
    if (c < 24) return 40 + (int'(c) - 20) * 8;
    if (c < 28) return 80 + (int'(c) - 24) * 16;
    return 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
  endtask

  task automatic doWrite(int m, int ch, logic [31:0] d);
    wr(DAT, d);
    wr(CTL, ctlw(m, ch, 0, 1'b0, 1'b1));
    waitIdle();
  endtask

  task automatic doRead(int m, int ch, int inc, output logic [31:0] d);
    wr(CTL, ctlw(m, ch, inc, 1'b1, 1'b1));
    waitIdle();
    rd(DAT, d);
  endtask

  initial begin
    for (int m = 0; m < 2; m++)
      for (int ch = 0; ch < NUM_CH; ch++)
        dbgStatus[(m * NUM_CH + ch) * 32 +: 32] = statWord(m, ch);
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int modes[4] = '{0, 1, 4, 5};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(CTL, v); chk("R1 ctl reset", v, 32'h0);
    rd(DAT, v); chk("R1 data reset", v, 32'h0);
    foreach (modes[i]) begin
      doRead(modes[i], NUM_CH - 1, 0, v);
      chk("R1 bank reset", v, 32'h0);
    end

    // R11 register map and field-only write
    rd(16'h3088, v); chk("R11 unmapped", v, 32'h0);
    wr(CTL, ctlw(4, 3, 2, 1'b1, 1'b0));
    rd(CTL, v); chk("R11 ctl readback", v, ctlw(4, 3, 2, 1'b1, 1'b0));

    // R10 capability
    rd(CAP, v);
    chk("R10 tx count", 32'(decode(v[22:18])), 32'(TX_VCH));
    chk("R10 rx count", 32'(decode(v[16:12])), 32'(RX_VCH));
    chk("R10 reserved bits", v & ~32'h007D_F000, 32'h0);

    // R2/R6 sweep writes over all banks and channels
    foreach (modes[i])
      for (int ch = 0; ch < NUM_CH; ch++) begin
        doWrite(modes[i], ch, pat(modes[i], ch));
        rd(DAT, v); chk("R2 data kept after write", v, pat(modes[i], ch));
      end
    // R3/R6 read back every entry
    foreach (modes[i])
      for (int ch = 0; ch < NUM_CH; ch++) begin
        doRead(modes[i], ch, 0, v);
        chk("R3 R6 readback", v, pat(modes[i], ch));
      end

    // R4 busy timing
    wr(CTL, ctlw(1, 2, 0, 1'b1, 1'b1));
    rd(CTL, v); chk("R4 busy cycle 1", 32'(v[0]), 32'd1);
    @(negedge clk); rd(CTL, v); chk("R4 busy cycle 2", 32'(v[0]), 32'd1);
    @(negedge clk); rd(CTL, v); chk("R4 busy cleared", 32'(v[0]), 32'd0);

    // R5 writes ignored while busy
    wr(DAT, 32'h1234_5678);
    wr(CTL, ctlw(0, 6, 0, 1'b0, 1'b1));
    wr(CTL, ctlw(5, 1, 0, 1'b1, 1'b1));
    @(negedge clk);
    rd(CTL, v); chk("R5 ctl fields kept", v, ctlw(0, 6, 0, 1'b0, 1'b0));
    wr(CTL, ctlw(0, 5, 0, 1'b0, 1'b1));
    wr(DAT, 32'hDEAD_BEEF);
    waitIdle();
    doRead(0, 5, 0, v); chk("R5 data write ignored", v, 32'h1234_5678);

    // R7 out-of-range channel and mode
    doWrite(0, NUM_CH, 32'hBAD0_0001);
    doRead(0, 0, 0, v); chk("R7 no alias store", v, pat(0, 0));
    doRead(0, NUM_CH, 0, v); chk("R7 bad channel reads 0", v, 32'h0);
    doRead(6, 1, 0, v); chk("R7 mode 6 reads 0", v, 32'h0);
    doRead(15, 1, 0, v); chk("R7 mode 15 reads 0", v, 32'h0);

    // R8 debug status views
    doWrite(2, 3, 32'hFFFF_0000);
    doRead(2, 3, 0, v); chk("R8 tx status", v, statWord(0, 3));
    for (int ch = 0; ch < NUM_CH; ch++) begin
      doRead(3, ch, 0, v); chk("R8 rx status", v, statWord(1, ch));
    end

    // R9 auto-increment
    doRead(1, 2, 1, v); chk("R9 data", v, pat(1, 2));
    rd(CTL, v); chk("R9 chan advanced", 32'(v[14:8]), 32'd3);
    doRead(4, 127, 3, v);
    rd(CTL, v); chk("R9 chan wraps", 32'(v[14:8]), 32'd0);
    doWrite(0, 1, 32'h0000_00AA);
    rd(CTL, v); chk("R9 no inc when field 0", 32'(v[14:8]), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule